// File: doc/BRIEF.md
# HDLC Status and Interrupt Register Unit

This block collects the condition flags of an HDLC controller into one byte that a host reads over a simple byte-wide bus. It also holds a byte-wide enable register that selects which flags may pull down a shared active-low interrupt line.

The flags come from two kinds of source. Event pulses from the receive and transmit engines set three sticky bits. These bits hold until the host reads the status byte. The other four bits are live level flags, computed every cycle from the occupancy counts of a receive FIFO and a transmit FIFO.

Each bus access is a one-cycle strobe. A small access state machine handles it. From `S_IDLE`, a read or write strobe moves the machine to one of five action states: `S_RD_STAT` (status read), `S_RD_MASK` (enable register read), `S_RD_NONE` (read of an unmapped address), `S_WR_MASK` (enable register write) or `S_WR_NONE` (write that is discarded). Every action state returns to `S_IDLE` on the next edge. The read data is loaded, and the sticky bits are cleared, on the edge that leaves an action state. If a read and a write strobe arrive together, the read takes priority. Strobes that arrive while the machine is busy are ignored.

Top module: `hdlc_irq_status`

## Requirements
- R1: In the status byte, bit 7 always reads 0. The other bits are: bit 6 receive-end, bit 5 receive-start, bit 4 receive-FIFO-above-half, bit 3 receive-FIFO-not-empty, bit 2 transmit-FIFO-below-half, bit 1 transmit-FIFO-has-space, bit 0 transmit-done.
- R2: A one-cycle pulse on any of `rx_frame_ok`, `rx_crc_err`, `rx_overrun` or `rx_abort` sets status bit 6 on the next clock edge.
- R3: A pulse on `rx_open_flag` sets status bit 5 on the next clock edge.
- R4: A pulse on `tx_msg_done` sets status bit 0 on the next clock edge.
- R5: With a FIFO depth of 64, bit 4 is 1 exactly when `rx_count` > 32, and bit 3 is 1 exactly when `rx_count` >= 1. Both follow the count in the same cycle.
- R6: Bit 2 is 1 exactly when `tx_count` < 32, and bit 1 is 1 exactly when `tx_count` < 64. Both follow the count in the same cycle.
- R7: A read strobe to address 0xB1 returns the status byte in `bus_rdata` two edges after the strobe. On that same second edge, bits 6, 5 and 0 are cleared.
- R8: If an event pulse is present in the clearing cycle of R7, its sticky bit stays set. The event then shows on the following status read.
- R9: A write to address 0xB2 loads the enable register from `bus_wdata` with bit 7 forced to 0. A read of 0xB2 returns the register.
- R10: `irq_n` is 0 exactly when some status bit and the same enable bit are both 1. It is therefore 1 whenever the enable register is zero.
- R11: After reset, the enable register and all sticky bits are 0 and `irq_n` is 1.
- R12: A read of any address other than 0xB1 or 0xB2 returns 0x00. A write to any address other than 0xB2, including 0xB1, changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, held until the next read |
| rx_frame_ok | input | 1 | Pulse: valid frame ended with a good CRC |
| rx_crc_err | input | 1 | Pulse: frame ended with a CRC error |
| rx_overrun | input | 1 | Pulse: receive overrun |
| rx_abort | input | 1 | Pulse: abort sequence received |
| rx_open_flag | input | 1 | Pulse: opening flag detected |
| tx_msg_done | input | 1 | Pulse: transmit message finished |
| rx_count | input | 7 | Receive FIFO occupancy |
| tx_count | input | 7 | Transmit FIFO occupancy |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A sticky event can arrive in the same cycle as the status read that clears it. The bench provokes this by raising an event pulse one cycle after the read strobe, in the cycle the machine spends in `S_RD_STAT`.

Two outcomes are judged. The read that is in progress must not show the event. The next read must show the bit set, and the read after that must show it cleared.

A checker also asserts that every event pulse is visible in the status byte one edge later, whatever clearing happens at that moment.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
    localparam int STAT_W = 8;

    localparam int B_RX_END   = 6;
    localparam int B_RX_START = 5;
    localparam int B_RX_HALF  = 4;
    localparam int B_RX_NE    = 3;
    localparam int B_TX_HALF  = 2;
    localparam int B_TX_NF    = 1;
    localparam int B_TX_DONE  = 0;

    localparam logic [7:0] ADDR_STATUS = 8'hB1;
    localparam logic [7:0] ADDR_ENABLE = 8'hB2;

    localparam logic [7:0] USED_BITS = 8'h7F;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STAT,
        S_RD_MASK,
        S_RD_NONE,
        S_WR_MASK,
        S_WR_NONE
    } bus_state_e;
endpackage

// File: rtl/hdlc_evt_latch.sv
module hdlc_evt_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                // A set in the clearing cycle wins, so no event is lost.
                bit_q <= set_i[i] | (bit_q & ~clr_i);
            end
        end
        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/hdlc_fifo_flags.sv
module hdlc_fifo_flags #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_half,
    output logic             rx_ne,
    output logic             tx_half_empty,
    output logic             tx_nf
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    always_comb begin
        rx_half       = rx_count > HALF;
        rx_ne         = rx_count != '0;
        tx_half_empty = tx_count < HALF;
        tx_nf         = tx_count < FULL;
    end
endmodule

// File: rtl/hdlc_bus_fsm.sv
module hdlc_bus_fsm
    import hdlc_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic [7:0]  status_i,
    output logic [7:0]  rdata_o,
    output logic [7:0]  mask_o,
    output logic        clr_o
);
    bus_state_e state_q, state_d;
    logic [7:0] wdata_q;
    logic [7:0] rdata_q;
    logic [7:0] mask_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (bus_rd) begin
                    if (bus_addr == ADDR_STATUS)      state_d = S_RD_STAT;
                    else if (bus_addr == ADDR_ENABLE) state_d = S_RD_MASK;
                    else                              state_d = S_RD_NONE;
                end else if (bus_wr) begin
                    if (bus_addr == ADDR_ENABLE)      state_d = S_WR_MASK;
                    else                              state_d = S_WR_NONE;
                end
            end
            S_RD_STAT, S_RD_MASK, S_RD_NONE,
            S_WR_MASK, S_WR_NONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata_q <= '0;
            mask_q  <= '0;
        end else begin
            if (state_q == S_IDLE && bus_wr) wdata_q <= bus_wdata;
            unique case (state_q)
                S_RD_STAT: rdata_q <= status_i & USED_BITS;
                S_RD_MASK: rdata_q <= mask_q;
                S_RD_NONE: rdata_q <= '0;
                S_WR_MASK: mask_q  <= wdata_q & USED_BITS;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_o   = (state_q == S_RD_STAT);
        rdata_o = rdata_q;
        mask_o  = mask_q;
    end
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
    import hdlc_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             rx_frame_ok,
    input  logic             rx_crc_err,
    input  logic             rx_overrun,
    input  logic             rx_abort,
    input  logic             rx_open_flag,
    input  logic             tx_msg_done,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             irq_n
);
    logic [2:0] evt_set, evt_q;
    logic       clr_sticky;
    logic       rx_half, rx_ne, tx_half_empty, tx_nf;
    logic [7:0] status_byte;
    logic [7:0] mask_byte;

    assign evt_set = {rx_frame_ok | rx_crc_err | rx_overrun | rx_abort,
                      rx_open_flag, tx_msg_done};

    hdlc_evt_latch #(.N(3)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (clr_sticky),
        .q_o   (evt_q)
    );

    hdlc_fifo_flags #(.DEPTH(FIFO_DEPTH)) u_lvl (
        .rx_count      (rx_count),
        .tx_count      (tx_count),
        .rx_half       (rx_half),
        .rx_ne         (rx_ne),
        .tx_half_empty (tx_half_empty),
        .tx_nf         (tx_nf)
    );

    always_comb begin
        status_byte             = '0;
        status_byte[B_RX_END]   = evt_q[2];
        status_byte[B_RX_START] = evt_q[1];
        status_byte[B_RX_HALF]  = rx_half;
        status_byte[B_RX_NE]    = rx_ne;
        status_byte[B_TX_HALF]  = tx_half_empty;
        status_byte[B_TX_NF]    = tx_nf;
        status_byte[B_TX_DONE]  = evt_q[0];
    end

    hdlc_bus_fsm u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_i  (status_byte),
        .rdata_o   (bus_rdata),
        .mask_o    (mask_byte),
        .clr_o     (clr_sticky)
    );

    assign irq_n = ~|(status_byte & mask_byte);
endmodule

// File: rtl/hdlc_irq_status_chk.sv
module hdlc_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_frame_ok,
    input logic       rx_crc_err,
    input logic       rx_overrun,
    input logic       rx_abort,
    input logic       rx_open_flag,
    input logic       tx_msg_done,
    input logic       clr,
    input logic [7:0] status_byte,
    input logic [7:0] mask_byte,
    input logic [7:0] bus_rdata,
    input logic       irq_n
);
    logic rx_end_any;
    assign rx_end_any = rx_frame_ok | rx_crc_err | rx_overrun | rx_abort;

    a_r1_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[7]);

    a_r2_rx_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end_any |=> status_byte[6]);

    a_r3_rx_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_open_flag |=> status_byte[5]);

    a_r4_tx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_msg_done |=> status_byte[0]);

    a_r7_clear_end: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rx_end_any) |=> !status_byte[6]);

    a_r8_keep_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rx_open_flag) |=> status_byte[5]);

    a_r9_mask_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_byte[7]);

    a_r10_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_byte == 8'h00) |-> irq_n);
endmodule

bind hdlc_irq_status hdlc_irq_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_frame_ok  (rx_frame_ok),
    .rx_crc_err   (rx_crc_err),
    .rx_overrun   (rx_overrun),
    .rx_abort     (rx_abort),
    .rx_open_flag (rx_open_flag),
    .tx_msg_done  (tx_msg_done),
    .clr          (clr_sticky),
    .status_byte  (status_byte),
    .mask_byte    (mask_byte),
    .bus_rdata    (bus_rdata),
    .irq_n        (irq_n)
);

// File: tb/hdlc_irq_status_tb.sv
`timescale 1ns/1ps
module hdlc_irq_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] evt = '0; // {tx_done, open, abort, overrun, crc, ok}
    logic [6:0] rx_count = '0, tx_count = '0;
    logic       irq_n;
    int         n_run = 0, n_fail = 0;
    logic [7:0] d;

    always #2.5 clk = ~clk;

    hdlc_irq_status u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_frame_ok(evt[0]), .rx_crc_err(evt[1]), .rx_overrun(evt[2]),
        .rx_abort(evt[3]), .rx_open_flag(evt[4]), .tx_msg_done(evt[5]),
        .rx_count(rx_count), .tx_count(tx_count), .irq_n(irq_n)
    );

    // {rx_count, tx_count, expected status bits 4..1}
    localparam logic [17:0] VEC [8] = '{
        {7'd0,  7'd0,  4'b0011},
        {7'd1,  7'd31, 4'b0111},
        {7'd32, 7'd32, 4'b0101},
        {7'd33, 7'd33, 4'b1101},
        {7'd64, 7'd64, 4'b1100},
        {7'd63, 7'd63, 4'b1101},
        {7'd31, 7'd30, 4'b0111},
        {7'd0,  7'd64, 4'b0000}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [5:0] ev, output logic [7:0] r);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; evt = ev;
        @(negedge clk); evt = '0; r = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [5:0] ev);
        @(negedge clk); evt = ev;
        @(negedge clk); evt = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 irq_n after reset", {7'd0, irq_n}, 8'h01);
        bus_read(8'hB2, 6'h00, d); check("R11 enable reg reset", d, 8'h00);
        bus_read(8'hB1, 6'h00, d); check("R1 R11 status after reset", d, 8'h06);

        for (int i = 0; i < 4; i++) begin
            pulse(6'(1 << i));
            bus_read(8'hB1, 6'h00, d); check("R2 receive-end cause", d, 8'h46);
            bus_read(8'hB1, 6'h00, d); check("R7 cleared after read", d, 8'h06);
        end
        pulse(6'h10);
        bus_read(8'hB1, 6'h00, d); check("R3 receive-start", d, 8'h26);
        pulse(6'h20);
        bus_read(8'hB1, 6'h00, d); check("R4 transmit-done", d, 8'h07);
        bus_read(8'hB1, 6'h00, d); check("R7 transmit-done cleared", d, 8'h06);

        // Same-cycle event and clear
        pulse(6'h01);
        bus_read(8'hB1, 6'h11, d); check("R8 read in progress", d, 8'h46);
        bus_read(8'hB1, 6'h00, d); check("R8 event kept", d, 8'h66);
        bus_read(8'hB1, 6'h00, d); check("R8 then cleared", d, 8'h06);

        bus_write(8'hB2, 8'hFF);
        bus_read(8'hB2, 6'h00, d); check("R9 bit 7 dropped", d, 8'h7F);
        check("R10 irq from live flags", {7'd0, irq_n}, 8'h00);
        bus_write(8'hB2, 8'h40);
        check("R10 live flags masked", {7'd0, irq_n}, 8'h01);
        pulse(6'h02);
        check("R10 irq on enabled event", {7'd0, irq_n}, 8'h00);
        bus_read(8'hB1, 6'h00, d);
        check("R10 irq released by read", {7'd0, irq_n}, 8'h01);

        bus_write(8'hB1, 8'h55);
        bus_read(8'hB2, 6'h00, d); check("R12 write to status ignored", d, 8'h40);
        bus_read(8'hB1, 6'h00, d); check("R12 status unchanged", d, 8'h06);
        bus_read(8'h10, 6'h00, d); check("R12 unmapped read", d, 8'h00);

        bus_write(8'hB2, 8'h1E);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx_count = VEC[i][17:11];
            tx_count = VEC[i][10:4];
            bus_read(8'hB1, 6'h00, d);
            check("R5 R6 level flags", d, {3'b000, VEC[i][3:0], 1'b0});
            check("R10 irq vs flags", {7'd0, irq_n}, {7'd0, VEC[i][3:0] == 4'b0000});
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule